// File: doc/BRIEF.md
# Rate-Matching Idle Inserter

This block sits between the read port of a receive rate-matching FIFO and the logic that consumes the stream. It handles a 64-bit data path with one control bit per byte, split into a lower and an upper 32-bit word. When the FIFO signals that it is nearly drained, the block adds eight bytes of Idle to the stream. This gives the FIFO time to refill when the incoming clock runs slower than the read clock. The added group is two whole Idle words, so no byte ever has to be shifted across the datapath.

An insertion can only follow an Idle word or an ordered-set word. If the upper word of the accepted beat is such a word, that beat goes out unchanged and a full Idle beat follows it. If the upper word is a Start and the lower word is an Idle or an ordered set, the Idle group is placed between the two words. The first output beat carries the original lower word with an Idle in the upper half. The second carries an Idle in the lower half with the Start moved to the upper half.

While an inserted beat is being produced, the block drops its ready signal toward the FIFO for one cycle, so the next input beat waits and is never lost. Every beat that carries inserted Idle bytes is marked with a flag that travels with it.

Top module: `idle_inserter`

## Requirements
- R1: After reset, out_valid and out_insert are 0 and in_ready is 1.
- R2: A beat accepted (in_valid and in_ready both 1) while almost_empty is 0 appears on out_data and out_ctrl one clock later, unchanged, with out_valid 1 and out_insert 0. Byte k is data bits [8k+7:8k] with control bit k. The lower word is bytes 0 to 3 and the upper word is bytes 4 to 7.
- R3: Word codes are as follows. An Idle word has all four control bits set and every byte equal to 0x07. An ordered-set word has control bits 0001 and byte 0 equal to 0x9C. A Start word has control bits 0001 and byte 0 equal to 0xFB. If a beat is accepted with almost_empty 1 and its upper word is Idle or ordered set, the beat is output unchanged with out_insert 0. The next output beat is all Idle in both words with out_insert 1.
- R4: If a beat is accepted with almost_empty 1, its upper word is Start and its lower word is Idle or ordered set, two beats are output. The first has the original lower word and an Idle upper word. The second has an Idle lower word and the original Start word as upper word. Both beats have out_insert 1.
- R5: Each insertion holds in_ready at 0 for exactly the one cycle after the triggering beat is accepted. An input beat presented during that cycle is accepted in the following cycle and output unchanged.
- R6: With almost_empty 1, an accepted beat whose upper word is a data word, or whose upper word is Start while its lower word is neither Idle nor ordered set, is output unchanged. No Idle beat follows it.
- R7: out_insert is 1 only on output beats that carry inserted Idle bytes, and only while out_valid is 1.
- R8: If no beat is accepted in a cycle where in_ready is 1, out_valid is 0 in the next cycle and nothing is inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | FIFO presents a beat |
| in_ready | output | 1 | Block accepts the presented beat |
| in_data | input | 64 | Input bytes, byte 0 in the least significant bits |
| in_ctrl | input | 8 | Input control bit per byte |
| almost_empty | input | 1 | FIFO nearly drained; request an Idle insertion |
| out_valid | output | 1 | Output beat present |
| out_data | output | 64 | Output bytes |
| out_ctrl | output | 8 | Output control bit per byte |
| out_insert | output | 1 | Output beat carries inserted Idle bytes |

## Verification
The bench builds the block with its default configuration: 8-bit lanes, eight lanes, and the Idle, ordered-set and Start codes given above. In that configuration each half-word falls into one of four classes (data, Idle, ordered set, Start). The sweep therefore covers every pairing of lower and upper class with almost_empty both low and high, which reaches each insertion form and each beat that must not be touched. A streaming run then presents a new beat during the stall cycle, to show that the held beat comes out intact after the inserted Idles.

// File: rtl/ir_pkg.sv
package ir_pkg;
   typedef enum logic [1:0] {
      WK_DATA  = 2'd0,
      WK_IDLE  = 2'd1,
      WK_OS    = 2'd2,
      WK_START = 2'd3
   } word_kind_t;

   typedef enum logic [1:0] {
      ST_PASS  = 2'd0,
      ST_FULL  = 2'd1,
      ST_SPLIT = 2'd2
   } ins_state_t;
endpackage

// File: rtl/ir_word_class.sv
module ir_word_class
   import ir_pkg::*;
#(
   parameter int          LANE_W     = 8,
   parameter int          HALF_LANES = 4,
   parameter logic [7:0]  IDLE_CH    = 8'h07,
   parameter logic [7:0]  OS_CH      = 8'h9C,
   parameter logic [7:0]  START_CH   = 8'hFB
) (
   input  logic [HALF_LANES*LANE_W-1:0] data,
   input  logic [HALF_LANES-1:0]        ctrl,
   output word_kind_t                   kind
);
   localparam int HALF_W = HALF_LANES * LANE_W;
   localparam logic [HALF_LANES-1:0] MARK_CTRL = HALF_LANES'(1);

   logic [HALF_LANES-1:0] lane_idle;

   for (genvar k = 0; k < HALF_LANES; k++) begin : g_lane
      assign lane_idle[k] = ctrl[k] && (data[k*LANE_W +: LANE_W] == LANE_W'(IDLE_CH));
   end

   logic marker;
   assign marker = (ctrl == MARK_CTRL);

   always_comb begin
      if (&lane_idle)                                             kind = WK_IDLE;
      else if (marker && data[LANE_W-1:0] == LANE_W'(OS_CH))      kind = WK_OS;
      else if (marker && data[LANE_W-1:0] == LANE_W'(START_CH))   kind = WK_START;
      else                                                        kind = WK_DATA;
   end

   logic unused_hi;
   assign unused_hi = ^data[HALF_W-1:LANE_W];
endmodule

// File: rtl/ir_core.sv
module ir_core
   import ir_pkg::*;
#(
   parameter int         LANE_W     = 8,
   parameter int         HALF_LANES = 4,
   parameter logic [7:0] IDLE_CH    = 8'h07
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   output logic                          in_ready,
   input  logic [2*HALF_LANES*LANE_W-1:0] in_data,
   input  logic [2*HALF_LANES-1:0]        in_ctrl,
   input  logic                          almost_empty,
   input  word_kind_t                    lo_kind,
   input  word_kind_t                    up_kind,
   output logic                          out_valid,
   output logic [2*HALF_LANES*LANE_W-1:0] out_data,
   output logic [2*HALF_LANES-1:0]        out_ctrl,
   output logic                          out_insert
);
   localparam int HALF_W = HALF_LANES * LANE_W;
   localparam logic [HALF_W-1:0]     IDLE_WORD = {HALF_LANES{LANE_W'(IDLE_CH)}};
   localparam logic [HALF_LANES-1:0] IDLE_CTRL = {HALF_LANES{1'b1}};

   ins_state_t            state;
   logic [HALF_W-1:0]     held_data;
   logic [HALF_LANES-1:0] held_ctrl;

   logic accept, up_boundary, lo_boundary, go_full, go_split;
   assign in_ready    = (state == ST_PASS);
   assign accept      = in_valid && in_ready;
   assign up_boundary = (up_kind == WK_IDLE) || (up_kind == WK_OS);
   assign lo_boundary = (lo_kind == WK_IDLE) || (lo_kind == WK_OS);
   assign go_full     = accept && almost_empty && up_boundary;
   assign go_split    = accept && almost_empty && (up_kind == WK_START) && lo_boundary;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_PASS;
         out_valid  <= 1'b0;
         out_insert <= 1'b0;
         out_data   <= '0;
         out_ctrl   <= '0;
         held_data  <= '0;
         held_ctrl  <= '0;
      end else begin
         case (state)
            ST_FULL: begin
               out_valid  <= 1'b1;
               out_insert <= 1'b1;
               out_data   <= {IDLE_WORD, IDLE_WORD};
               out_ctrl   <= {IDLE_CTRL, IDLE_CTRL};
               state      <= ST_PASS;
            end
            ST_SPLIT: begin
               out_valid  <= 1'b1;
               out_insert <= 1'b1;
               out_data   <= {held_data, IDLE_WORD};
               out_ctrl   <= {held_ctrl, IDLE_CTRL};
               state      <= ST_PASS;
            end
            default: begin
               out_valid <= accept;
               if (go_split) begin
                  out_insert <= 1'b1;
                  out_data   <= {IDLE_WORD, in_data[HALF_W-1:0]};
                  out_ctrl   <= {IDLE_CTRL, in_ctrl[HALF_LANES-1:0]};
                  held_data  <= in_data[2*HALF_W-1:HALF_W];
                  held_ctrl  <= in_ctrl[2*HALF_LANES-1:HALF_LANES];
                  state      <= ST_SPLIT;
               end else begin
                  out_insert <= 1'b0;
                  if (accept) begin
                     out_data <= in_data;
                     out_ctrl <= in_ctrl;
                  end
                  state <= go_full ? ST_FULL : ST_PASS;
               end
            end
         endcase
      end
   end

   assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !almost_empty) |=>
         (out_valid && !out_insert && out_data == $past(in_data) && out_ctrl == $past(in_ctrl)));

   assert_full_sequence_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && almost_empty && up_boundary) |=>
         (!out_insert && out_data == $past(in_data)) ##1 (out_insert && (&out_ctrl)));

   assert_split_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && almost_empty && up_kind == WK_START && lo_boundary) |=>
         (out_insert && out_data[HALF_W-1:0] == $past(in_data[HALF_W-1:0])));

   assert_single_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |=> in_ready);

   assert_stall_after_insert_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && almost_empty && up_boundary) |=> !in_ready);

   assert_flag_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_insert |-> out_valid);

   assert_gap_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid) |=> (!out_valid && !out_insert));
endmodule

// File: rtl/idle_inserter.sv
module idle_inserter
   import ir_pkg::*;
#(
   parameter int         LANE_W   = 8,
   parameter int         LANES    = 8,
   parameter logic [7:0] IDLE_CH  = 8'h07,
   parameter logic [7:0] OS_CH    = 8'h9C,
   parameter logic [7:0] START_CH = 8'hFB
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [LANES*LANE_W-1:0] in_data,
   input  logic [LANES-1:0]        in_ctrl,
   input  logic                    almost_empty,
   output logic                    out_valid,
   output logic [LANES*LANE_W-1:0] out_data,
   output logic [LANES-1:0]        out_ctrl,
   output logic                    out_insert
);
   localparam int HALF_LANES = LANES / 2;
   localparam int HALF_W     = HALF_LANES * LANE_W;

   if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
      $error("idle_inserter: LANES must be even and at least 2");
   end
   if (LANE_W < 8) begin : g_bad_width
      $error("idle_inserter: LANE_W must hold an 8-bit code");
   end

   word_kind_t kind [2];

   for (genvar h = 0; h < 2; h++) begin : g_half
      ir_word_class #(
         .LANE_W(LANE_W), .HALF_LANES(HALF_LANES),
         .IDLE_CH(IDLE_CH), .OS_CH(OS_CH), .START_CH(START_CH)
      ) u_class (
         .data(in_data[h*HALF_W +: HALF_W]),
         .ctrl(in_ctrl[h*HALF_LANES +: HALF_LANES]),
         .kind(kind[h])
      );
   end

   ir_core #(
      .LANE_W(LANE_W), .HALF_LANES(HALF_LANES), .IDLE_CH(IDLE_CH)
   ) u_core (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_ctrl(in_ctrl),
      .almost_empty(almost_empty),
      .lo_kind(kind[0]), .up_kind(kind[1]),
      .out_valid(out_valid), .out_data(out_data),
      .out_ctrl(out_ctrl), .out_insert(out_insert)
   );
endmodule

// File: tb/tb_idle_inserter.sv
module tb_idle_inserter;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [63:0] in_data = '0;
   logic [7:0]  in_ctrl = '0;
   logic        almost_empty = 1'b0;
   logic        out_valid;
   logic [63:0] out_data;
   logic [7:0]  out_ctrl;
   logic        out_insert;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   idle_inserter dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_ctrl(in_ctrl),
      .almost_empty(almost_empty),
      .out_valid(out_valid), .out_data(out_data),
      .out_ctrl(out_ctrl), .out_insert(out_insert)
   );

   // word kinds: 0 data, 1 Idle, 2 ordered set, 3 Start; returns {ctrl, data}
   function automatic logic [35:0] mk_word(input int kind, input int seed);
      logic [7:0] s;
      s = 8'(seed * 13 + 5);
      case (kind)
         1:       return {4'hF, 32'h07070707};
         2:       return {4'h1, s, 8'h5A, 8'h00, 8'h9C};
         3:       return {4'h1, s, 8'h55, 8'hD5, 8'hFB};
         default: return {4'h0, s, s ^ 8'h3C, 8'h07, 8'hFB};
      endcase
   endfunction

   task automatic check(input string req, input logic [72:0] act, input logic [72:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [72:0] obs();
      return {out_valid, out_insert, out_ctrl, out_data};
   endfunction

   localparam logic [35:0] IDLE_W = {4'hF, 32'h07070707};

   task automatic run_case(input int lo_k, input int up_k, input bit ae, input int seed);
      logic [35:0] lo, up;
      bit full, split, elig;
      logic [72:0] e1, e2;
      lo = mk_word(lo_k, seed);
      up = mk_word(up_k, seed + 1);
      full  = ae && (up_k == 1 || up_k == 2);
      split = ae && up_k == 3 && (lo_k == 1 || lo_k == 2);
      elig  = full || split;
      @(negedge clk);
      in_data = {up[31:0], lo[31:0]};
      in_ctrl = {up[35:32], lo[35:32]};
      in_valid = 1'b1;
      almost_empty = ae;
      check("R5 ready before beat", {72'b0, in_ready}, 73'd1);
      if (split) e1 = {1'b1, 1'b1, IDLE_W[35:32], lo[35:32], IDLE_W[31:0], lo[31:0]};
      else       e1 = {1'b1, 1'b0, up[35:32], lo[35:32], up[31:0], lo[31:0]};
      if (full)  e2 = {1'b1, 1'b1, IDLE_W[35:32], IDLE_W[35:32], IDLE_W[31:0], IDLE_W[31:0]};
      else       e2 = {1'b1, 1'b1, up[35:32], IDLE_W[35:32], up[31:0], IDLE_W[31:0]};
      @(negedge clk);
      in_valid = 1'b0;
      if (split)     check("R4 first beat", obs(), e1);
      else if (full) check("R3 unchanged beat", obs(), e1);
      else if (ae)   check("R6 untouched beat", obs(), e1);
      else           check("R2 pass-through", obs(), e1);
      check("R5 ready during insertion", {72'b0, in_ready}, {72'b0, !elig});
      @(negedge clk);
      if (split)     check("R4 second beat", obs(), e2);
      else if (full) check("R3 idle beat", obs(), e2);
      else           check("R8 no beat, R6 no insert", {71'b0, out_valid, out_insert}, 73'd0);
      check("R7 flag only with inserted idle", {72'b0, out_insert}, {72'b0, elig});
   endtask

   initial begin
      logic [35:0] a_up, a_lo, b_up, b_lo;
      repeat (3) @(negedge clk);
      check("R1 reset state", {70'b0, out_valid, out_insert, in_ready}, 73'd1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 idle input", {71'b0, out_valid, out_insert}, 73'd0);

      for (int ae = 0; ae < 2; ae++)
         for (int lo_k = 0; lo_k < 4; lo_k++)
            for (int up_k = 0; up_k < 4; up_k++)
               run_case(lo_k, up_k, bit'(ae), lo_k * 4 + up_k);

      // streaming: beat B waits through the stall cycle
      a_lo = mk_word(0, 40); a_up = mk_word(1, 41);
      b_lo = mk_word(2, 42); b_up = mk_word(0, 43);
      @(negedge clk);
      in_data = {a_up[31:0], a_lo[31:0]}; in_ctrl = {a_up[35:32], a_lo[35:32]};
      in_valid = 1'b1; almost_empty = 1'b1;
      @(negedge clk);
      in_data = {b_up[31:0], b_lo[31:0]}; in_ctrl = {b_up[35:32], b_lo[35:32]};
      check("R3 stream first beat", obs(),
            {2'b10, a_up[35:32], a_lo[35:32], a_up[31:0], a_lo[31:0]});
      check("R5 stall", {72'b0, in_ready}, 73'd0);
      @(negedge clk);
      check("R3 stream idle beat", obs(), {2'b11, 8'hFF, 64'h0707070707070707});
      check("R5 ready back", {72'b0, in_ready}, 73'd1);
      @(negedge clk);
      in_valid = 1'b0; almost_empty = 1'b0;
      check("R5 held beat intact", obs(),
            {2'b10, b_up[35:32], b_lo[35:32], b_up[31:0], b_lo[31:0]});
      @(negedge clk);
      check("R8 drained", {71'b0, out_valid, out_insert}, 73'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule